// File: doc/BRIEF.md
# Baseline Saturation Reset Controller

This controller guards a differential gain stage whose baseline can drift out of range when an electrode is disturbed or reattached. It watches the digitized voltages at the two inputs of the stage. Each input code is signed and measured against common mode. When exactly one branch sits far above common mode for long enough, the controller raises a reset that shorts the stage and pulls it back to mid-scale. Once the reset is released, normal operation continues.

Each branch has its own detector. A detector is a one-sided comparator with wide hysteresis, followed by a persistence counter that advances only on sample strobes. A short excursion, such as a clipped QRS peak over a healthy baseline, never lasts long enough to qualify. The reset request is the exclusive OR of the two qualified detector flags. A small state machine turns that request into a pulse of programmable length, counted in strobes. After the pulse comes a holdoff of the same length.

The state machine has three states. IDLE waits for a request, and IDLE to FIRE is taken in the clock after the request is seen. FIRE drives the reset, and FIRE to HOLD is taken on the strobe that completes the pulse length. HOLD blocks new pulses, and HOLD to IDLE is taken on the strobe that completes the holdoff. While the machine is in FIRE, both persistence counters are flushed, so any excursion must qualify again from zero.

Top module: `baseline_reset_ctrl`

## Requirements
- R1: A synchronous active-low reset clears both detectors, both persistence counters and the state machine, so `stage_rst` reads 0 and a partially counted excursion is forgotten.
- R2: A detector sets only on a strobe whose sample is strictly greater than `cfg_trip`. A sample equal to the trip point, or any negative sample however large, never sets it.
- R3: A set detector stays set until a strobe brings a sample strictly below `cfg_trip - cfg_hyst`. A sample at or above that level keeps it set, and its persistence count keeps growing.
- R4: A detector qualifies once it has been set on `cfg_qual` consecutive strobes. A run of fewer strobes, or a run broken by a release, produces no reset.
- R5: The reset request is the XOR of the two qualified flags. When both branches qualify together, no reset is issued.
- R6: `stage_rst` rises one clock after the strobe that completes qualification. It stays high for exactly `cfg_pulse` strobes, which is `cfg_pulse` cycles when strobes arrive every cycle.
- R7: After `stage_rst` falls, at least `cfg_pulse` strobes must pass before it can rise again. With a request held and strobes every cycle, successive rises are `cfg_pulse + max(cfg_qual, cfg_pulse) + 1` cycles apart.
- R8: While `stage_rst` is high, the persistence counters are held at zero. A new pulse therefore needs a full new run of `cfg_qual` strobes counted after the pulse.
- R9: Cycles with `smp_vld` low do not advance or clear any counter or detector, and the sample inputs are ignored in those cycles.
- R10: A `cfg_qual` or `cfg_pulse` value of 0 selects the parameter defaults `QUAL_DEF` and `PULSE_DEF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe; counters advance only when high |
| smp_pos | input | DATA_W | Signed code of the positive-branch input, relative to common mode |
| smp_neg | input | DATA_W | Signed code of the negative-branch input, relative to common mode |
| cfg_trip | input | DATA_W-1 | Trip point, as a positive magnitude above common mode |
| cfg_hyst | input | DATA_W-1 | Hysteresis below the trip point that is needed to release |
| cfg_qual | input | CNT_W | Qualification length in strobes (0 selects QUAL_DEF) |
| cfg_pulse | input | CNT_W | Reset pulse and holdoff length in strobes (0 selects PULSE_DEF) |
| stage_rst | output | 1 | Reset to the gain stage; high shorts the stage to common mode |

## Verification
The bench builds the block with `DATA_W = 8`, `CNT_W = 5`, `QUAL_DEF = 5` and `PULSE_DEF = 3`. These values keep every qualification and pulse window to a handful of strobes. That makes it possible to sweep each burst length from one strobe up to the qualification length over several qualification and pulse pairs, including pairs where qualification is shorter than the holdoff and pairs where it is longer. Each burst's expected outcome, rise cycle, pulse width and retrigger spacing is computed arithmetically from the configuration. Trip, hysteresis-edge, negative and two-branch samples are set at the exact code boundaries of the 8-bit range.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } bsr_state_e;

    localparam int unsigned BRANCHES = 2;

endpackage

// File: rtl/bsr_detector.sv
module bsr_detector #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned CNT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe,
    input  logic                     flush,
    input  logic signed [DATA_W-1:0] sample,
    input  logic [DATA_W-2:0]        trip,
    input  logic [DATA_W-2:0]        hyst,
    input  logic [CNT_W-1:0]         qual_len,
    output logic                     qualified
);
    localparam int unsigned EXT_W = DATA_W + 1;

    logic signed [EXT_W-1:0] s_ext;
    logic signed [EXT_W-1:0] trip_ext;
    logic signed [EXT_W-1:0] low_ext;
    logic                    cmp_q;
    logic                    cmp_d;
    logic [CNT_W-1:0]        cnt;
    logic [CNT_W-1:0]        cnt_d;

    assign s_ext    = {sample[DATA_W-1], sample};
    assign trip_ext = {2'b00, trip};
    assign low_ext  = trip_ext - $signed({2'b00, hyst});

    // one-sided comparator with wide hysteresis
    always_comb begin
        if (cmp_q) begin
            cmp_d = (s_ext >= low_ext);
        end else begin
            cmp_d = (s_ext > trip_ext);
        end
    end

    // persistence counter, saturating at the qualification length
    always_comb begin
        cnt_d = cnt;
        if (flush) begin
            cnt_d = '0;
        end else if (strobe) begin
            if (!cmp_d) begin
                cnt_d = '0;
            end else if (cnt < qual_len) begin
                cnt_d = cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
            cnt   <= '0;
        end else begin
            if (strobe) begin
                cmp_q <= cmp_d;
            end
            cnt <= cnt_d;
        end
    end

    assign qualified = cmp_q && (cnt >= qual_len);

    assert_gap_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !flush) |=> ($stable(cnt) && $stable(cmp_q)));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));

    assert_strict_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_q) |-> ($past(s_ext) > $past(trip_ext)));

    assert_release_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp_q) |-> ($past(s_ext) < $past(low_ext)));

endmodule

// File: rtl/bsr_pulse_fsm.sv
module bsr_pulse_fsm #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             req,
    input  logic [CNT_W-1:0] pulse_len,
    output logic             stage_rst,
    output logic             flush
);
    import bsr_pkg::*;

    bsr_state_e       state;
    bsr_state_e       state_nxt;
    logic [CNT_W-1:0] tcnt;
    logic             last;

    assign last = (tcnt == pulse_len - 1'b1);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (req)            state_nxt = ST_FIRE;
            ST_FIRE: if (strobe && last) state_nxt = ST_HOLD;
            ST_HOLD: if (strobe && last) state_nxt = ST_IDLE;
            default:                     state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tcnt  <= '0;
        end else begin
            state <= state_nxt;
            if (state_nxt != state) begin
                tcnt <= '0;
            end else if (strobe && (state != ST_IDLE)) begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        stage_rst = 1'b0;
        flush     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_FIRE: begin
                stage_rst = 1'b1;
                flush     = 1'b1;
            end
            ST_HOLD: ;
            default: ;
        endcase
    end

    // checker state: strobes seen since the pulse last fell
    logic [CNT_W-1:0] gap_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '1;
        end else if (stage_rst) begin
            gap_cnt <= '0;
        end else if (strobe && (gap_cnt != '1)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_rst) |-> $past(req));

    assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_rst) |-> (gap_cnt >= pulse_len));

endmodule

// File: rtl/baseline_reset_ctrl.sv
module baseline_reset_ctrl #(
    parameter int unsigned DATA_W    = 12,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned QUAL_DEF  = 64,
    parameter int unsigned PULSE_DEF = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic signed [DATA_W-1:0] smp_pos,
    input  logic signed [DATA_W-1:0] smp_neg,
    input  logic [DATA_W-2:0]        cfg_trip,
    input  logic [DATA_W-2:0]        cfg_hyst,
    input  logic [CNT_W-1:0]         cfg_qual,
    input  logic [CNT_W-1:0]         cfg_pulse,
    output logic                     stage_rst
);
    import bsr_pkg::*;

    localparam logic [CNT_W-1:0] QUAL_D  = CNT_W'(QUAL_DEF);
    localparam logic [CNT_W-1:0] PULSE_D = CNT_W'(PULSE_DEF);

    logic [CNT_W-1:0]               qual_eff;
    logic [CNT_W-1:0]               pulse_eff;
    logic signed [DATA_W-1:0]       branch_smp [BRANCHES];
    logic [BRANCHES-1:0]            qual_flag;
    logic                           req;
    logic                           flush;

    assign qual_eff  = (cfg_qual  == '0) ? QUAL_D  : cfg_qual;
    assign pulse_eff = (cfg_pulse == '0) ? PULSE_D : cfg_pulse;

    assign branch_smp[0] = smp_pos;
    assign branch_smp[1] = smp_neg;

    for (genvar b = 0; b < BRANCHES; b++) begin : g_branch
        bsr_detector #(
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W)
        ) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .strobe    (smp_vld),
            .flush     (flush),
            .sample    (branch_smp[b]),
            .trip      (cfg_trip),
            .hyst      (cfg_hyst),
            .qual_len  (qual_eff),
            .qualified (qual_flag[b])
        );
    end

    assign req = ^qual_flag;

    bsr_pulse_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (smp_vld),
        .req       (req),
        .pulse_len (pulse_eff),
        .stage_rst (stage_rst),
        .flush     (flush)
    );

    assert_both_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&qual_flag) |=> !$rose(stage_rst));

endmodule

// File: tb/baseline_reset_ctrl_bench.sv
module baseline_reset_ctrl_bench;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 5;
    localparam int QDEF   = 5;
    localparam int PDEF   = 3;
    localparam int TRIP   = 40;
    localparam int HYST   = 15;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     smp_vld = 1'b0;
    logic signed [DATA_W-1:0] smp_pos = '0;
    logic signed [DATA_W-1:0] smp_neg = '0;
    logic [DATA_W-2:0]        cfg_trip = 7'(TRIP);
    logic [DATA_W-2:0]        cfg_hyst = 7'(HYST);
    logic [CNT_W-1:0]         cfg_qual = 5'd4;
    logic [CNT_W-1:0]         cfg_pulse = 5'd6;
    logic                     stage_rst;

    baseline_reset_ctrl #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .QUAL_DEF  (QDEF),
        .PULSE_DEF (PDEF)
    ) u_baseline_reset_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .smp_pos   (smp_pos),
        .smp_neg   (smp_neg),
        .cfg_trip  (cfg_trip),
        .cfg_hyst  (cfg_hyst),
        .cfg_qual  (cfg_qual),
        .cfg_pulse (cfg_pulse),
        .stage_rst (stage_rst)
    );

    always #10 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int rises = 0;
    int hi = 0;
    int r1 = 0;
    int r2 = 0;
    int start = 0;
    logic prev = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (stage_rst && !prev) begin
            rises = rises + 1;
            if (rises == 1) r1 = cyc;
            if (rises == 2) r2 = cyc;
        end
        if (stage_rst) hi = hi + 1;
        prev = stage_rst;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0; smp_vld = 1'b0; smp_pos = '0; smp_neg = '0;
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        rises = 0; hi = 0; r1 = 0; r2 = 0;
    endtask

    task automatic drive(input int p, input int n, input bit v, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk); #1;
            if (i == 0) start = cyc;
            smp_pos = 8'(p); smp_neg = 8'(n); smp_vld = v;
        end
    endtask

    task automatic set_cfg(input int q, input int p);
        cfg_qual = 5'(q); cfg_pulse = 5'(p);
    endtask

    initial begin
        #(20 * 150000);
        nfail++;
        $display("FAIL watchdog expired actual %0d expected 0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int qs [4] = '{2, 4, 6, 9};
        int ps [4] = '{3, 6, 3, 3};
        int s0;
        set_cfg(4, 6);
        do_reset();
        drive(0, 0, 1, 2);
        check(stage_rst == 1'b0, "R1 reset state", stage_rst, 0);

        // R1: reset forgets a partial count
        drive(60, 0, 1, 3);
        do_reset();
        drive(60, 0, 1, 1);
        drive(0, 0, 1, 15);
        check(rises == 0, "R1 partial count cleared", rises, 0);

        // R4/R6/R7/R8 sweep over configurations
        for (int c = 0; c < 4; c++) begin
            set_cfg(qs[c], ps[c]);
            for (int len = 1; len <= qs[c]; len++) begin
                do_reset();
                drive(60, 0, 1, len);
                s0 = start;
                drive(0, 0, 1, 3 * ps[c] + qs[c] + 4);
                if (len < qs[c]) begin
                    check(rises == 0, "R4 short burst ignored", rises, 0);
                end else begin
                    check(rises == 1, "R4 single reset on full run", rises, 1);
                    check(r1 == s0 + qs[c] + 1, "R6 rise latency", r1 - s0, qs[c] + 1);
                    check(hi == ps[c], "R6 pulse width", hi, ps[c]);
                end
            end
            // held step: retrigger spacing
            do_reset();
            drive(60, 0, 1, 3 * (qs[c] + ps[c]) + 6);
            check(rises >= 2, "R7 held step refires after holdoff", rises, 2);
            check(r2 - r1 == ps[c] + ((qs[c] > ps[c]) ? qs[c] : ps[c]) + 1,
                  "R8 R7 retrigger spacing", r2 - r1,
                  ps[c] + ((qs[c] > ps[c]) ? qs[c] : ps[c]) + 1);
            drive(0, 0, 1, 30);
        end

        set_cfg(4, 6);
        // R2: equal to trip, negative excursion, one above trip
        do_reset();
        drive(TRIP, 0, 1, 20);
        check(rises == 0, "R2 sample equal to trip", rises, 0);
        do_reset();
        drive(-128, 0, 1, 20);
        check(rises == 0, "R2 negative sample", rises, 0);
        do_reset();
        drive(TRIP + 1, 0, 1, 4);
        drive(0, 0, 1, 20);
        check(rises == 1, "R2 one code above trip", rises, 1);

        // R3: hysteresis keeps the detector set at the low edge
        do_reset();
        drive(60, 0, 1, 2);
        drive(TRIP - HYST, 0, 1, 2);
        drive(0, 0, 1, 20);
        check(rises == 1, "R3 held at low edge", rises, 1);
        do_reset();
        drive(60, 0, 1, 3);
        drive(TRIP - HYST - 1, 0, 1, 1);
        drive(60, 0, 1, 3);
        drive(0, 0, 1, 20);
        check(rises == 0, "R3 release below low edge", rises, 0);

        // R5: both branches qualified
        do_reset();
        drive(60, 60, 1, 30);
        check(rises == 0, "R5 both branches block", rises, 0);
        do_reset();
        drive(0, 60, 1, 4);
        drive(0, 0, 1, 20);
        check(rises == 1, "R5 negative branch alone fires", rises, 1);

        // R9: strobe gaps ignore samples
        do_reset();
        drive(60, 0, 1, 3);
        drive(0, 0, 0, 10);
        check(rises == 0, "R9 no fire during gap", rises, 0);
        drive(60, 0, 1, 1);
        drive(0, 0, 1, 20);
        check(rises == 1, "R9 count survives gap", rises, 1);

        // R10: zero configuration selects defaults
        set_cfg(0, 0);
        do_reset();
        drive(60, 0, 1, QDEF);
        s0 = start;
        drive(0, 0, 1, 20);
        check(r1 - s0 == QDEF + 1, "R10 default qualification", r1 - s0, QDEF + 1);
        check(hi == PDEF, "R10 default pulse", hi, PDEF);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule